// File: doc/BRIEF.md
# Dual-Limit Alternating Timer Output

This block is a 16-bit up-counter that drives a single timer output pin. The counter starts at zero and runs up to a programmed limit. When it gets there it goes back to zero. In single-limit mode the pin is normally high. It drops for one clock each time the limit is reached, which gives a periodic strobe.

In dual-limit mode the counter alternates between a primary and a secondary limit. The pin is high while the primary limit is in control and low while the secondary limit is in control. The two limits therefore set the lengths of the high and low phases of a waveform with a programmable duty cycle.

The counter never advances faster than one step every fourth clock. Steps come either from an internal quarter-rate slot or from rising edges of an external clock pin. The external pin is synchronized and edge-detected, and each edge is then counted in the next quarter-rate slot. A continuous-run control selects between free running and stopping after one complete cycle. Dropping the enable returns the timer to its idle state at once.

Top module: `dual_limit_timer`

## Requirements
- R1: In single-limit mode `tmr_out` goes low for exactly one clock. This happens in the clock after the step that takes `count` from `limit_a`-1 back to 0, and `tmr_out` is high at all other times.
- R2: In dual-limit mode `tmr_out` equals the inverse of `active_b`. The primary phase (`active_b`=0) lasts `limit_a` steps and the secondary phase (`active_b`=1) lasts `limit_b` steps, after which control returns to the primary limit.
- R3: A limit value of 0 means 65536 steps. The counter keeps incrementing past every nonzero value and does not wrap early.
- R4: With `ext_sel`=0 the counter advances exactly once in every fourth clock. The slot comes from a free-running phase counter that is cleared by reset, so the first possible step is on the fourth clock edge after reset.
- R5: With `ext_sel`=1 the counter advances once per rising edge of `ext_clk`. The edge passes a two-flop synchronizer and an edge detector, and is consumed in the next quarter-rate slot. Edges spaced at least four clocks apart are never lost.
- R6: With `continuous`=0 the timer stops after one complete cycle. In single-limit mode this is one `limit_a` period; in dual-limit mode it is a primary phase plus a secondary phase. After stopping, `count` holds at 0, `active_b` is 0 and `tmr_out` is high until `enable` is dropped and raised again.
- R7: After reset, and one clock after `enable` is low, `count` is 0, `active_b` is 0 and `tmr_out` is high.
- R8: In single-limit mode only `limit_a` is used. `active_b` is 0 one clock after `dual_mode` is low, even if the secondary limit was in control.
- R9: With `continuous`=1 the timer repeats its cycle with no gap in stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low forces the idle state |
| continuous | input | 1 | 1 = free run, 0 = stop after one cycle |
| dual_mode | input | 1 | 1 = alternate primary/secondary limits |
| ext_sel | input | 1 | 1 = count external clock edges |
| ext_clk | input | 1 | Asynchronous external count input |
| limit_a | input | 16 | Primary limit (0 means 65536) |
| limit_b | input | 16 | Secondary limit (0 means 65536) |
| tmr_out | output | 1 | Registered timer output pin |
| count | output | 16 | Current count value |
| active_b | output | 1 | 1 while the secondary limit is in control |

## Verification
The bench goes after the terminal step, where an off-by-one compare would make every phase one step too long or too short. That error shows up as a wrong low-run length in dual-limit mode. It also checks the zero limit: a design that treats 0 as "no count" would pulse constantly instead of counting past 100.

The external path is driven with slow edges. A design that forgets the pending flag drops edges that arrive outside a slot, and one that skips edge detection counts an edge on every clock the input is high; either would give the wrong pulse count.

One-shot runs and mid-run mode and enable changes catch a design that never halts, restarts by itself, or leaves the secondary limit selected after leaving dual-limit mode.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  typedef enum logic {
    SEL_PRIMARY   = 1'b0,
    SEL_SECONDARY = 1'b1
  } lim_sel_e;
endpackage

// File: rtl/dlt_tick_gen.sv
// Step generator: quarter-rate slot, external edge synchronizer and
// a pending flag that holds an edge until the next slot.
module dlt_tick_gen #(
  parameter int PRESCALE_LOG2 = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sel,
  input  logic ext_clk,
  output logic tick
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [PRESCALE_LOG2-1:0] phase;
  logic [CHAIN_W-1:0]       chain;
  logic                     pend;
  logic                     slot;
  logic                     ext_edge;

  assign slot     = &phase;
  assign ext_edge = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign tick     = slot & (ext_sel ? pend : 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      chain <= '0;
      pend  <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
      chain <= {chain[CHAIN_W-2:0], ext_clk};
      if (ext_sel) pend <= ext_edge | (pend & ~slot);
      else         pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dlt_count_core.sv
// Counter, limit selection and halt control.
module dlt_count_core
  import dlt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             continuous,
  input  logic             dual_mode,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit_a,
  input  logic [CNT_W-1:0] limit_b,
  output logic [CNT_W-1:0] count,
  output lim_sel_e         sel,
  output lim_sel_e         sel_nxt,
  output logic             pulse_nxt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_nxt;
  logic             terminal;
  logic             halted;
  logic             halted_nxt;

  always_comb begin
    lim        = (dual_mode && sel == SEL_SECONDARY) ? limit_b : limit_a;
    // wraps at the counter width, so a zero limit means full range
    terminal   = ((count + ONE) == lim);
    cnt_nxt    = count;
    sel_nxt    = dual_mode ? sel : SEL_PRIMARY;
    halted_nxt = halted;
    pulse_nxt  = 1'b0;
    if (!enable) begin
      cnt_nxt    = '0;
      sel_nxt    = SEL_PRIMARY;
      halted_nxt = 1'b0;
    end else if (tick && !halted) begin
      if (terminal) begin
        cnt_nxt = '0;
        if (dual_mode) begin
          if (sel == SEL_SECONDARY) begin
            sel_nxt    = SEL_PRIMARY;
            halted_nxt = !continuous;
          end else begin
            sel_nxt = SEL_SECONDARY;
          end
        end else begin
          pulse_nxt  = 1'b1;
          halted_nxt = !continuous;
        end
      end else begin
        cnt_nxt = count + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      sel    <= SEL_PRIMARY;
      halted <= 1'b0;
    end else begin
      count  <= cnt_nxt;
      sel    <= sel_nxt;
      halted <= halted_nxt;
    end
  end
endmodule

// File: rtl/dlt_out_stage.sv
// Registered output pin.
module dlt_out_stage
  import dlt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     enable,
  input  logic     dual_mode,
  input  lim_sel_e sel_nxt,
  input  logic     pulse_nxt,
  output logic     pin
);
  always_ff @(posedge clk) begin
    if (rst)            pin <= 1'b1;
    else if (!enable)   pin <= 1'b1;
    else if (dual_mode) pin <= (sel_nxt == SEL_PRIMARY);
    else                pin <= ~pulse_nxt;
  end
endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer
  import dlt_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int PRESCALE_LOG2 = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             continuous,
  input  logic             dual_mode,
  input  logic             ext_sel,
  input  logic             ext_clk,
  input  logic [CNT_W-1:0] limit_a,
  input  logic [CNT_W-1:0] limit_b,
  output logic             tmr_out,
  output logic [CNT_W-1:0] count,
  output logic             active_b
);
  logic     tick;
  lim_sel_e sel;
  lim_sel_e sel_nxt;
  logic     pulse_nxt;

  dlt_tick_gen #(
    .PRESCALE_LOG2(PRESCALE_LOG2),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .ext_sel(ext_sel),
    .ext_clk(ext_clk),
    .tick   (tick)
  );

  dlt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .continuous(continuous),
    .dual_mode (dual_mode),
    .tick      (tick),
    .limit_a   (limit_a),
    .limit_b   (limit_b),
    .count     (count),
    .sel       (sel),
    .sel_nxt   (sel_nxt),
    .pulse_nxt (pulse_nxt)
  );

  dlt_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .dual_mode(dual_mode),
    .sel_nxt  (sel_nxt),
    .pulse_nxt(pulse_nxt),
    .pin      (tmr_out)
  );

  assign active_b = (sel == SEL_SECONDARY);
endmodule

// File: rtl/dlt_checker.sv
module dlt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             dual_mode,
  input logic             tmr_out,
  input logic [CNT_W-1:0] count,
  input logic             active_b
);
  // R1: the single-mode strobe never lasts two clocks
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(enable && !dual_mode) && enable && !dual_mode && !tmr_out) |=> tmr_out);

  // R2: in dual mode the pin level marks the limit in control
  p_dual_level_r2: assert property (@(posedge clk) disable iff (rst)
    $past(enable && dual_mode) |-> (tmr_out == !active_b));

  // R4: after a step the count holds on the next clock
  p_quarter_rate_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && count != $past(count)) |=> (count == $past(count)));

  // R7: disabled timer is idle
  p_disabled_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!enable) |-> (tmr_out && count == '0 && !active_b));

  // R8: single mode never keeps the secondary limit
  p_single_primary_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!dual_mode) |-> !active_b);
endmodule

bind dual_limit_timer dlt_checker #(.CNT_W(CNT_W)) u_dlt_checker (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .dual_mode(dual_mode),
  .tmr_out  (tmr_out),
  .count    (count),
  .active_b (active_b)
);

// File: tb/test_dual_limit_timer.sv
`timescale 1ns/1ps
module test_dual_limit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        continuous = 1'b1;
  logic        dual_mode = 1'b0;
  logic        ext_sel = 1'b0;
  logic        ext_clk = 1'b0;
  logic [15:0] limit_a = 16'd5;
  logic [15:0] limit_b = 16'd5;
  logic        tmr_out;
  logic [15:0] count;
  logic        active_b;

  int checks = 0;
  int errors = 0;
  string cur_req = "R7";

  always #2.5 clk = ~clk;

  dual_limit_timer i_dual_limit_timer (
    .clk(clk), .rst(rst), .enable(enable), .continuous(continuous),
    .dual_mode(dual_mode), .ext_sel(ext_sel), .ext_clk(ext_clk),
    .limit_a(limit_a), .limit_b(limit_b), .tmr_out(tmr_out),
    .count(count), .active_b(active_b)
  );

  // ---------------- behavioural reference ----------------
  int m_ph, m_cnt, m_lim;
  bit m_e1, m_e2, m_e3, m_pend, m_sel, m_halt, m_out, m_started;
  bit slot, edge_seen, step, pulse, nsel;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0; m_pend = 0;
      m_cnt = 0; m_sel = 0; m_halt = 0; m_out = 1;
      m_started = 1;
    end else begin
      slot      = (m_ph == 3);
      edge_seen = m_e2 && !m_e3;
      step      = slot && (ext_sel ? m_pend : 1'b1);
      m_lim     = (dual_mode && m_sel) ? int'(limit_b) : int'(limit_a);
      if (m_lim == 0) m_lim = 65536;
      if (!enable) begin
        m_cnt = 0; m_sel = 0; m_halt = 0; m_out = 1;
      end else begin
        pulse = 0;
        nsel  = dual_mode ? m_sel : 1'b0;
        if (step && !m_halt) begin
          if (m_cnt + 1 == m_lim) begin
            m_cnt = 0;
            if (dual_mode) begin
              if (m_sel) begin nsel = 0; if (!continuous) m_halt = 1; end
              else nsel = 1;
            end else begin
              pulse = 1;
              if (!continuous) m_halt = 1;
            end
          end else m_cnt = m_cnt + 1;
        end
        m_sel = nsel;
        m_out = dual_mode ? !m_sel : !pulse;
      end
      m_ph   = (m_ph + 1) % 4;
      m_pend = ext_sel ? (edge_seen || (m_pend && !slot)) : 1'b0;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison and statistics
  int low_runs, cur_run, max_run, last_chg, min_gap, cyc;
  logic [15:0] prev_cnt;
  bit prev_out;

  task automatic clear_stats();
    low_runs = 0; cur_run = 0; max_run = 0; min_gap = 1000; last_chg = -1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (m_started) begin
      check(tmr_out === m_out, cur_req, "tmr_out", int'(tmr_out), int'(m_out));
      check(count === 16'(m_cnt), cur_req, "count", int'(count), m_cnt);
      check(active_b === m_sel, cur_req, "active_b", int'(active_b), int'(m_sel));
      if (!tmr_out) begin
        if (prev_out) low_runs++;
        cur_run++;
        if (cur_run > max_run) max_run = cur_run;
      end else cur_run = 0;
      if (enable && count != prev_cnt) begin
        if (last_chg >= 0 && cyc - last_chg < min_gap) min_gap = cyc - last_chg;
        last_chg = cyc;
      end
      prev_out = tmr_out;
      prev_cnt = count;
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input bit dm, input bit cont, input bit es,
                         input logic [15:0] la, input logic [15:0] lb);
    enable = 0;
    wait_clks(2);
    dual_mode = dm; continuous = cont; ext_sel = es;
    limit_a = la; limit_b = lb;
    wait_clks(2);
    clear_stats();
    enable = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_stats();
    prev_out = 1; prev_cnt = 0;
    wait_clks(3);
    rst = 0;
    wait_clks(1);
    // R7 reset state
    check(tmr_out === 1'b1 && count === 16'd0 && active_b === 1'b0,
          "R7", "reset idle", int'(tmr_out), 1);

    // R1, R4, R9: single mode, internal rate, continuous
    cur_req = "R1";
    restart(0, 1, 0, 16'd5, 16'd9);
    wait_clks(200);
    check(min_gap == 4, "R4", "count step spacing", min_gap, 4);
    check(max_run == 1, "R1", "low pulse width", max_run, 1);
    check(low_runs >= 9 && low_runs <= 10, "R9", "repeating strobes", low_runs, 10);

    // R2: dual mode duty cycle
    cur_req = "R2";
    restart(1, 1, 0, 16'd3, 16'd6);
    wait_clks(300);
    check(max_run == 24, "R2", "secondary phase clocks", max_run, 24);
    check(low_runs >= 7, "R9", "dual cycles repeat", low_runs, 8);

    // R6: dual one-shot
    cur_req = "R6";
    restart(1, 0, 0, 16'd2, 16'd2);
    wait_clks(100);
    check(low_runs == 1 && max_run == 8, "R6", "dual one-shot low run", max_run, 8);
    check(count == 0 && tmr_out && !active_b, "R6", "dual halted idle", int'(count), 0);

    // R6: single one-shot
    restart(0, 0, 0, 16'd4, 16'd4);
    wait_clks(100);
    check(low_runs == 1, "R6", "single one-shot strobes", low_runs, 1);

    // R3: zero limit means full range
    cur_req = "R3";
    restart(0, 1, 0, 16'd0, 16'd0);
    wait_clks(400);
    check(count == 16'd100, "R3", "count past 99 with zero limit", int'(count), 100);
    check(low_runs == 0, "R3", "no early wrap", low_runs, 0);

    // R5: external edges
    cur_req = "R5";
    ext_clk = 0;
    restart(0, 1, 1, 16'd4, 16'd4);
    wait_clks(3);
    for (int i = 0; i < 20; i++) begin
      ext_clk = 1; wait_clks(7);
      ext_clk = 0; wait_clks(7);
    end
    wait_clks(20);
    check(low_runs == 5, "R5", "strobes from 20 edges", low_runs, 5);
    check(count == 16'd0, "R5", "count after 20 edges", int'(count), 0);

    // R8: leave dual mode while secondary is in control
    cur_req = "R8";
    restart(1, 1, 0, 16'd2, 16'd50);
    wait_clks(20);
    check(active_b == 1'b1, "R8", "secondary reached", int'(active_b), 1);
    dual_mode = 0;
    wait_clks(1);
    check(active_b == 1'b0, "R8", "primary after mode change", int'(active_b), 0);

    // R7: disable mid-run
    cur_req = "R7";
    restart(0, 1, 0, 16'd40, 16'd4);
    wait_clks(30);
    enable = 0;
    wait_clks(1);
    check(count == 0 && tmr_out && !active_b, "R7", "disable clears", int'(count), 0);
    wait_clks(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule